// File: doc/BRIEF.md
# Fractional-Increment Precision Time Counter

This block keeps a network-synchronised wall time as a 48-bit seconds field, a 32-bit nanoseconds field and a 20-bit sub-nanosecond fraction. On every clock edge it adds a programmable period value to the nanosecond and fraction pair. The nanosecond count folds back at one billion and carries into the seconds field. Because the period is held with 20 fractional bits, software can run the counter from any clock of 25 MHz or faster. Software can also retune the period while the counter runs, so that its rate follows a remote master clock.

Software sets or corrects the time with a one-shot step write. The write either loads an absolute seconds and nanoseconds value or applies a signed offset. A one-cycle pulse marks each seconds rollover. A snapshot strobe captures the full time into a holding register, so a reader sees seconds, nanoseconds and fraction from the same instant.

Top module: `frac_time_counter`

## Requirements
- R1: After reset the time outputs, the snapshot outputs and `sec_pulse` are zero, and the period register holds 8 ns (8·2^20 in its fixed-point format).
- R2: On every edge without a step write, {`time_ns`,`time_frac`} grows by the period register, counted in units of 2^-20 ns.
- R3: `time_ns` never leaves 0..999,999,999. When the sum reaches 10^9 ns or more, 10^9 ns is removed and `time_sec` rises by one on the same edge.
- R4: `time_sec` wraps from all ones to zero on a rollover.
- R5: `sec_pulse` is high for exactly the one cycle after the edge on which the period addition rolled the seconds field over. A step write never raises it.
- R6: `inc_val` is 26 bits: bits 25:20 hold whole nanoseconds and bits 19:0 hold the fraction. A value written with `inc_we` on edge k is not used on edge k, and it is the amount added from edge k+1 onward.
- R7: A step write with `step_rel`=0 loads `step_sec` and `step_ns` (which must be below 10^9), clears the fraction, and replaces the period addition on that edge.
- R8: A step write with `step_rel`=1 adds (`step_neg`=0) or subtracts (`step_neg`=1) the offset `step_sec`/`step_ns` (with `step_ns` below 10^9). It carries or borrows between the fields, keeps the fraction, works modulo 2^48 seconds, and replaces the period addition on that edge.
- R9: `snap_req` on an edge copies the time as it stood just before that edge into `snap_sec`/`snap_ns`/`snap_frac`. Without `snap_req` the snapshot outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock, 25 MHz or faster |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_we | input | 1 | Write strobe for the period register |
| inc_val | input | 26 | New period, 6 integer + 20 fraction ns bits |
| step_we | input | 1 | One-shot step write strobe |
| step_rel | input | 1 | 0 = absolute load, 1 = signed offset |
| step_neg | input | 1 | Offset sign, 1 = subtract |
| step_sec | input | 48 | Step seconds value |
| step_ns | input | 32 | Step nanoseconds value |
| snap_req | input | 1 | Capture strobe for the snapshot register |
| time_sec | output | 48 | Live seconds field |
| time_ns | output | 32 | Live nanoseconds field |
| time_frac | output | 20 | Live sub-nanosecond fraction |
| sec_pulse | output | 1 | One-cycle pulse after each seconds rollover |
| snap_sec | output | 48 | Captured seconds |
| snap_ns | output | 32 | Captured nanoseconds |
| snap_frac | output | 20 | Captured fraction |

## Verification
The period addition is driven with the default 8 ns period, with whole-nanosecond periods up to 40 ns, and with random fractional periods. The fractional cases show whether the fraction carries correctly into the nanoseconds field, a fault that whole-number periods hide. Absolute steps that land a few nanoseconds before a second boundary force rollovers. With those seconds values, all-ones landings separate a correct modular wrap from a saturating or sign-confused one. Signed offsets that do and do not cross a second boundary, including a borrow below second zero, test the carry and borrow logic apart from the plain addition.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int DEF_SEC_W      = 48;
  localparam int DEF_NS_W       = 32;
  localparam int DEF_FRAC_W     = 20;
  localparam int DEF_INC_INT_W  = 6;
  localparam int DEF_NS_PER_SEC = 1_000_000_000;
  localparam int DEF_RESET_NS   = 8;
endpackage

// File: rtl/ftc_rate_reg.sv
module ftc_rate_reg #(
  parameter int INC_W    = 26,
  parameter int FRAC_W   = 20,
  parameter int RESET_NS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_we,
  input  logic [INC_W-1:0] inc_val,
  output logic [INC_W-1:0] inc_q
);
  localparam logic [INC_W-1:0] RESET_INC = INC_W'(RESET_NS) << FRAC_W;

  always_ff @(posedge clk) begin
    if (!rst_n)      inc_q <= RESET_INC;
    else if (inc_we) inc_q <= inc_val;
  end

  // R6: without a write the period stays put
  p_rate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_we |=> $stable(inc_q));
endmodule

// File: rtl/ftc_next_time.sv
module ftc_next_time #(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 32,
  parameter int FRAC_W     = 20,
  parameter int INC_W      = 26,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [NS_W-1:0]   cur_ns,
  input  logic [FRAC_W-1:0] cur_frac,
  input  logic [INC_W-1:0]  inc,
  input  logic              step_we,
  input  logic              step_rel,
  input  logic              step_neg,
  input  logic [SEC_W-1:0]  step_sec,
  input  logic [NS_W-1:0]   step_ns,
  output logic [SEC_W-1:0]  nxt_sec,
  output logic [NS_W-1:0]   nxt_ns,
  output logic [FRAC_W-1:0] nxt_frac,
  output logic              tick_rollover
);
  localparam int FX_W = NS_W + FRAC_W + 1;
  localparam logic [FX_W-1:0] WRAP_FX = FX_W'(NS_PER_SEC) << FRAC_W;
  localparam logic [NS_W:0]   WRAP_NS = (NS_W+1)'(NS_PER_SEC);

  // fixed-point sum of the current time and the period
  function automatic logic [FX_W-1:0] fx_sum(input logic [NS_W-1:0] ns,
                                             input logic [FRAC_W-1:0] fr,
                                             input logic [INC_W-1:0] step);
    return {1'b0, ns, fr} + FX_W'(step);
  endfunction

  // nanoseconds moved forward by d, before folding
  function automatic logic [NS_W:0] ns_fwd(input logic [NS_W-1:0] ns,
                                           input logic [NS_W-1:0] d);
    return {1'b0, ns} + {1'b0, d};
  endfunction

  // nanoseconds moved back by d, folded into range when borrow is set
  function automatic logic [NS_W:0] ns_back(input logic [NS_W-1:0] ns,
                                            input logic [NS_W-1:0] d,
                                            input logic borrow);
    return borrow ? ({1'b0, ns} + WRAP_NS - {1'b0, d}) : ({1'b0, ns} - {1'b0, d});
  endfunction

  logic [FX_W-1:0]   sum_fx, tick_fx;
  logic              tick_wrap;
  logic [NS_W:0]     fwd_raw, fwd_fold, back_fold;
  logic              rel_carry, rel_borrow;
  logic [SEC_W-1:0]  rel_sec;
  logic [NS_W-1:0]   rel_ns;

  always_comb begin
    sum_fx    = fx_sum(cur_ns, cur_frac, inc);
    tick_wrap = (sum_fx >= WRAP_FX);
    tick_fx   = tick_wrap ? (sum_fx - WRAP_FX) : sum_fx;

    fwd_raw    = ns_fwd(cur_ns, step_ns);
    rel_carry  = (fwd_raw >= WRAP_NS);
    fwd_fold   = rel_carry ? (fwd_raw - WRAP_NS) : fwd_raw;
    rel_borrow = (cur_ns < step_ns);
    back_fold  = ns_back(cur_ns, step_ns, rel_borrow);

    if (step_neg) begin
      rel_sec = cur_sec - step_sec - SEC_W'(rel_borrow);
      rel_ns  = back_fold[NS_W-1:0];
    end else begin
      rel_sec = cur_sec + step_sec + SEC_W'(rel_carry);
      rel_ns  = fwd_fold[NS_W-1:0];
    end

    tick_rollover = 1'b0;
    if (step_we && !step_rel) begin
      nxt_sec  = step_sec;
      nxt_ns   = step_ns;
      nxt_frac = '0;
    end else if (step_we) begin
      nxt_sec  = rel_sec;
      nxt_ns   = rel_ns;
      nxt_frac = cur_frac;
    end else begin
      tick_rollover = tick_wrap;
      nxt_sec  = cur_sec + SEC_W'(tick_wrap);
      nxt_ns   = tick_fx[FRAC_W +: NS_W];
      nxt_frac = tick_fx[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/ftc_snapshot.sv
module ftc_snapshot #(
  parameter int W = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         snap_req,
  input  logic [W-1:0] live,
  output logic [W-1:0] snap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        snap_q <= '0;
    else if (snap_req) snap_q <= live;
  end

  // R9: the holding register changes only on a capture
  p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> $stable(snap_q));
endmodule

// File: rtl/frac_time_counter.sv
module frac_time_counter #(
  parameter int SEC_W      = ftc_pkg::DEF_SEC_W,
  parameter int NS_W       = ftc_pkg::DEF_NS_W,
  parameter int FRAC_W     = ftc_pkg::DEF_FRAC_W,
  parameter int INC_INT_W  = ftc_pkg::DEF_INC_INT_W,
  parameter int NS_PER_SEC = ftc_pkg::DEF_NS_PER_SEC,
  parameter int RESET_NS   = ftc_pkg::DEF_RESET_NS,
  localparam int INC_W     = INC_INT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_we,
  input  logic [INC_W-1:0]  inc_val,
  input  logic              step_we,
  input  logic              step_rel,
  input  logic              step_neg,
  input  logic [SEC_W-1:0]  step_sec,
  input  logic [NS_W-1:0]   step_ns,
  input  logic              snap_req,
  output logic [SEC_W-1:0]  time_sec,
  output logic [NS_W-1:0]   time_ns,
  output logic [FRAC_W-1:0] time_frac,
  output logic              sec_pulse,
  output logic [SEC_W-1:0]  snap_sec,
  output logic [NS_W-1:0]   snap_ns,
  output logic [FRAC_W-1:0] snap_frac
);
  localparam int TIME_W = SEC_W + NS_W + FRAC_W;
  localparam int FX_W   = NS_W + FRAC_W;

  logic [INC_W-1:0]  inc_q;
  logic [SEC_W-1:0]  nxt_sec;
  logic [NS_W-1:0]   nxt_ns;
  logic [FRAC_W-1:0] nxt_frac;
  logic              tick_rollover;
  logic [TIME_W-1:0] snap_q;

  ftc_rate_reg #(.INC_W(INC_W), .FRAC_W(FRAC_W), .RESET_NS(RESET_NS)) u_rate (
    .clk(clk), .rst_n(rst_n), .inc_we(inc_we), .inc_val(inc_val), .inc_q(inc_q));

  ftc_next_time #(.SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(INC_W),
                  .NS_PER_SEC(NS_PER_SEC)) u_next (
    .cur_sec(time_sec), .cur_ns(time_ns), .cur_frac(time_frac), .inc(inc_q),
    .step_we(step_we), .step_rel(step_rel), .step_neg(step_neg),
    .step_sec(step_sec), .step_ns(step_ns),
    .nxt_sec(nxt_sec), .nxt_ns(nxt_ns), .nxt_frac(nxt_frac),
    .tick_rollover(tick_rollover));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_sec  <= '0;
      time_ns   <= '0;
      time_frac <= '0;
      sec_pulse <= 1'b0;
    end else begin
      time_sec  <= nxt_sec;
      time_ns   <= nxt_ns;
      time_frac <= nxt_frac;
      sec_pulse <= tick_rollover;
    end
  end

  ftc_snapshot #(.W(TIME_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .snap_req(snap_req),
    .live({time_sec, time_ns, time_frac}), .snap_q(snap_q));

  assign {snap_sec, snap_ns, snap_frac} = snap_q;

  // R3: nanoseconds stay below one second
  p_ns_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    time_ns < NS_W'(NS_PER_SEC));

  // R3 / R4: a rollover bumps seconds by one, modulo the field width
  p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rollover |=> time_sec == $past(time_sec) + SEC_W'(1));

  // R2: plain cycle adds exactly the period
  p_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_we && !tick_rollover) |=>
      {time_ns, time_frac} == $past({time_ns, time_frac}) + FX_W'($past(inc_q)));

  // R5: pulse only when seconds just advanced, never twice in a row
  p_pulse_sec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> time_sec == $past(time_sec) + SEC_W'(1));
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);

  // R7: absolute load lands verbatim with the fraction cleared
  p_abs_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_we && !step_rel && step_ns < NS_W'(NS_PER_SEC)) |=>
      (time_sec == $past(step_sec) && time_ns == $past(step_ns) && time_frac == '0));

  // R8: an offset keeps the fraction
  p_rel_frac_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_we && step_rel) |=> $stable(time_frac));
endmodule

// File: tb/frac_time_counter_bench.sv
module frac_time_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        d_inc_we = 1'b0;
  logic [25:0] d_inc_val = '0;
  logic        d_step_we = 1'b0, d_step_rel = 1'b0, d_step_neg = 1'b0;
  logic [47:0] d_step_sec = '0;
  logic [31:0] d_step_ns = '0;
  logic        d_snap = 1'b0;

  logic [47:0] time_sec, snap_sec;
  logic [31:0] time_ns, snap_ns;
  logic [19:0] time_frac, snap_frac;
  logic        sec_pulse;

  frac_time_counter u_frac_time_counter (
    .clk(clk), .rst_n(rst_n), .inc_we(d_inc_we), .inc_val(d_inc_val),
    .step_we(d_step_we), .step_rel(d_step_rel), .step_neg(d_step_neg),
    .step_sec(d_step_sec), .step_ns(d_step_ns), .snap_req(d_snap),
    .time_sec(time_sec), .time_ns(time_ns), .time_frac(time_frac),
    .sec_pulse(sec_pulse), .snap_sec(snap_sec), .snap_ns(snap_ns),
    .snap_frac(snap_frac));

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R2";

  // bench model
  logic [47:0] m_sec = '0, ms_sec = '0;
  logic [31:0] m_ns = '0, ms_ns = '0;
  logic [19:0] m_frac = '0, ms_frac = '0;
  logic [25:0] m_inc = 26'd8 << 20;
  logic        m_pulse = 1'b0;

  localparam logic [95:0] BILLION = 96'd1_000_000_000;
  localparam logic [95:0] SPAN    = (96'd1 << 48) * BILLION;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // period addition restated as a total count of 2^-20 ns units
  function automatic logic [63:0] units_of(input logic [31:0] ns, input logic [19:0] fr);
    return ({32'd0, ns} * 64'd1048576) + {44'd0, fr};
  endfunction

  task automatic model_tick();
    logic [63:0] total, lim;
    lim   = 64'd1_000_000_000 * 64'd1048576;
    total = units_of(m_ns, m_frac) + {38'd0, m_inc};
    m_pulse = 1'b0;
    if (total >= lim) begin
      total   = total - lim;
      m_sec   = m_sec + 48'd1;
      m_pulse = 1'b1;
    end
    m_ns   = 32'(total / 64'd1048576);
    m_frac = 20'(total % 64'd1048576);
  endtask

  // offset restated as a flat nanosecond count modulo 2^48 seconds
  task automatic model_offset();
    logic [95:0] abs_ns, off_ns, res;
    abs_ns = {48'd0, m_sec} * BILLION + {64'd0, m_ns};
    off_ns = {48'd0, d_step_sec} * BILLION + {64'd0, d_step_ns};
    if (d_step_neg) res = (abs_ns + SPAN - off_ns) % SPAN;
    else            res = (abs_ns + off_ns) % SPAN;
    m_sec = 48'(res / BILLION);
    m_ns  = 32'(res % BILLION);
  endtask

  task automatic run_cycle();
    if (d_snap) begin
      ms_sec = m_sec; ms_ns = m_ns; ms_frac = m_frac;
    end
    m_pulse = 1'b0;
    if (d_step_we && !d_step_rel) begin
      m_sec = d_step_sec; m_ns = d_step_ns; m_frac = '0;
    end else if (d_step_we) begin
      model_offset();
    end else begin
      model_tick();
    end
    if (d_inc_we) m_inc = d_inc_val;
    @(posedge clk);
    @(negedge clk);
    chk({time_sec, time_ns, time_frac} == {m_sec, m_ns, m_frac}, cur_req, "time",
        {28'd0, time_sec, time_ns, time_frac}, {28'd0, m_sec, m_ns, m_frac});
    chk(sec_pulse == m_pulse, "R5", "sec_pulse", 128'(sec_pulse), 128'(m_pulse));
    chk({snap_sec, snap_ns, snap_frac} == {ms_sec, ms_ns, ms_frac}, "R9", "snapshot",
        {28'd0, snap_sec, snap_ns, snap_frac}, {28'd0, ms_sec, ms_ns, ms_frac});
    d_inc_we = 1'b0; d_step_we = 1'b0; d_snap = 1'b0;
  endtask

  task automatic do_abs(input logic [47:0] s, input logic [31:0] n);
    d_step_we = 1'b1; d_step_rel = 1'b0; d_step_neg = 1'b0;
    d_step_sec = s; d_step_ns = n;
    run_cycle();
  endtask

  task automatic do_rel(input bit neg, input logic [47:0] s, input logic [31:0] n);
    d_step_we = 1'b1; d_step_rel = 1'b1; d_step_neg = neg;
    d_step_sec = s; d_step_ns = n;
    run_cycle();
  endtask

  task automatic do_inc(input logic [25:0] v);
    d_inc_we = 1'b1; d_inc_val = v;
    run_cycle();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk({time_sec, time_ns, time_frac, sec_pulse} == '0, "R1", "reset time",
        128'({time_sec, time_ns, time_frac}), 128'd0);
    chk({snap_sec, snap_ns, snap_frac} == '0, "R1", "reset snapshot",
        128'({snap_sec, snap_ns, snap_frac}), 128'd0);
    rst_n = 1'b1;
    cur_req = "R1";
    repeat (4) run_cycle();

    // R3 / R5 / R7: land just below a boundary and roll over
    cur_req = "R7";
    do_abs(48'd5, 32'd999_999_990);
    cur_req = "R3";
    repeat (3) run_cycle();

    // R4: seconds all ones wrap to zero
    cur_req = "R4";
    do_abs(48'hFFFF_FFFF_FFFF, 32'd999_999_996);
    repeat (2) run_cycle();

    // R6: fractional period, then the slowest supported clock
    cur_req = "R6";
    do_inc((26'd8 << 20) | 26'd1);
    repeat (3) run_cycle();
    do_inc(26'd40 << 20);
    d_snap = 1'b1;
    run_cycle();
    repeat (2) run_cycle();

    // R8: offsets with carry, borrow and below-zero wrap
    cur_req = "R8";
    do_abs(48'd10, 32'd600_000_000);
    do_rel(1'b0, 48'd2, 32'd700_000_000);
    do_rel(1'b1, 48'd1, 32'd900_000_000);
    do_abs(48'd0, 32'd100);
    do_rel(1'b1, 48'd0, 32'd200);
    do_inc((26'd7 << 20) | 26'h5A5A5);
    run_cycle();
    do_rel(1'b0, 48'd3, 32'd0);

    // R9: capture while a step lands on the same edge
    cur_req = "R9";
    d_snap = 1'b1;
    do_abs(48'd77, 32'd123);
    run_cycle();

    // random mix
    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      int pick;
      pick = $urandom_range(199, 0);
      d_snap = ($urandom_range(7, 0) == 0);
      if (pick < 4) begin
        d_inc_we  = 1'b1;
        d_inc_val = {6'($urandom_range(40, 1)), 20'($urandom)};
      end
      if (pick >= 4 && pick < 8) begin
        d_step_we = 1'b1; d_step_rel = 1'b0; d_step_neg = 1'b0;
        d_step_sec = {16'($urandom), 32'($urandom)};
        d_step_ns  = 32'd1_000_000_000 - 32'($urandom_range(400, 1));
      end else if (pick >= 8 && pick < 11) begin
        d_step_we = 1'b1; d_step_rel = 1'b1; d_step_neg = pick[0];
        d_step_sec = {16'($urandom), 32'($urandom)};
        d_step_ns  = 32'($urandom_range(999_999_999, 0));
      end
      run_cycle();
    end
    finish_run();
  end
endmodule